// File: doc/BRIEF.md
# Zero-Block IDCT Skip Controller

This block walks the six 8x8 blocks of each decoded macroblock toward an inverse DCT unit. For every block it decides, from flags already parsed out of the bitstream and before any coefficient is looked at, whether the inverse transform has to run or whether the block is known to be all zero. A macroblock marked as not coded is all zero in every block. An inter-coded block is also all zero when both its DC-nonzero flag and its coded-pattern bit are clear. Intra-coded blocks always run.

When a block runs, the controller enables the transform datapath clock, pulses a start strobe and then waits for the transform's done handshake. When a block is skipped, the datapath clock enable stays low. The controller then raises a bypass flag for exactly 64 cycles, one for each sample. Downstream logic forces a zero sample in each of those cycles, so output timing matches that of a computed block. A one-cycle done pulse follows the sixth block, and the controller then returns to idle.

Top module: `zblk_skip_ctrl`

## Requirements
- R1: After reset, mbReady is 1, and idctClkEn, idctStart, bypass and mbDone are 0.
- R2: A mbStart seen while mbReady is 1 captures codIn, cbpIn, dcNzIn and isInter. Blocks are then visited with blkIdx 0,1,2,3 (luminance), 4 (blue chroma) and 5 (red chroma), in that order. Bit b of cbpIn and of dcNzIn belongs to block b.
- R3: With codIn=0 and isInter=1, block b is skipped exactly when cbpIn[b]=0 and dcNzIn[b]=0. Otherwise it runs.
- R4: With codIn=1, all six blocks are skipped, whatever the other flags are.
- R5: With codIn=0 and isInter=0 (intra), no block is skipped.
- R6: A skipped block holds bypass high for exactly 64 consecutive cycles with blkIdx steady. idctClkEn is 0 throughout.
- R7: In the decision cycle of a block (the cycle after the start for block 0, or two cycles after the previous block ends), idctClkEn and idctStart are both 1 for a block that runs. Both are 0 for a block that is skipped, so the clock enable is already low one cycle before bypass rises.
- R8: A running block keeps idctClkEn high, with bypass low, until a cycle in which idctDone is 1. In the cycle after that, idctClkEn is 0.
- R9: One cycle after a block ends (after its idctDone cycle, or after its last bypass cycle), mbDone is 1 if blkIdx is 5. In the cycle after that, mbReady is 1. mbDone is 0 for blocks 0 to 4.
- R10: mbStart and flag inputs that arrive while mbReady is 0 are ignored. The current macroblock goes on using the flags captured at its start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| mbStart | input | 1 | Start a macroblock (taken only when idle) |
| codIn | input | 1 | Macroblock not coded: all blocks zero |
| cbpIn | input | 6 | Coded pattern, one bit per block (AC content present) |
| dcNzIn | input | 6 | DC coefficient nonzero, one bit per block |
| isInter | input | 1 | 1 for inter-coded, 0 for intra-coded macroblock |
| idctDone | input | 1 | Transform finished the current block |
| mbReady | output | 1 | Idle, ready for a new macroblock |
| idctClkEn | output | 1 | Clock enable for the transform datapath |
| idctStart | output | 1 | One-cycle start strobe for a running block |
| bypass | output | 1 | Force a zero output sample this cycle |
| blkIdx | output | 3 | Index of the block being handled |
| mbDone | output | 1 | One-cycle pulse after block 5 ends |

## Verification
The skip decision is tried with a macroblock marked not coded but carrying nonzero pattern bits, which separates the override from the per-block rule. An intra macroblock with all flags clear shows that the all-zero test is not applied to intra blocks. Inter macroblocks with all flags clear, with all flags set, and with alternating DC and pattern bits show that each block reads its own bits in the correct position and that either flag alone keeps a block running. Random flags, random transform latencies, and junk on mbStart and the flag inputs while a macroblock is in progress then mix skip and run sequences and check that inputs outside idle are ignored.

// File: rtl/zblk_pkg.sv
package zblk_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DECIDE,
    ST_RUN,
    ST_ZERO,
    ST_NEXT
  } state_t;

  typedef struct packed {
    logic load;    // capture macroblock flags, clear block index
    logic incIdx;  // advance to the next block
    logic clrCnt;  // clear zero-sample counter
    logic incCnt;  // count one zero sample
  } strobe_t;
endpackage

// File: rtl/zblk_dp.sv
module zblk_dp
  import zblk_pkg::*;
#(
  parameter int NUM_BLOCKS = 6,
  parameter int SAMPLES    = 64,
  localparam int IDXW = $clog2(NUM_BLOCKS),
  localparam int CNTW = $clog2(SAMPLES)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  strobe_t               strobe,
  input  logic                  codIn,
  input  logic [NUM_BLOCKS-1:0] cbpIn,
  input  logic [NUM_BLOCKS-1:0] dcNzIn,
  input  logic                  isInter,
  output logic [IDXW-1:0]       blkIdx,
  output logic                  skipNow,
  output logic                  lastBlk,
  output logic                  lastSample
);
  logic                  codQ;
  logic                  interQ;
  logic [NUM_BLOCKS-1:0] cbpQ;
  logic [NUM_BLOCKS-1:0] dcQ;
  logic [CNTW-1:0]       zeroCnt;
  logic [NUM_BLOCKS-1:0] blkSkip;
  logic [2**IDXW-1:0]    blkSkipPad;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      codQ   <= 1'b0;
      interQ <= 1'b0;
      cbpQ   <= '0;
      dcQ    <= '0;
    end else if (strobe.load) begin
      codQ   <= codIn;
      interQ <= isInter;
      cbpQ   <= cbpIn;
      dcQ    <= dcNzIn;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      blkIdx <= '0;
    end else if (strobe.load) begin
      blkIdx <= '0;
    end else if (strobe.incIdx) begin
      blkIdx <= blkIdx + IDXW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      zeroCnt <= '0;
    end else if (strobe.clrCnt) begin
      zeroCnt <= '0;
    end else if (strobe.incCnt) begin
      zeroCnt <= zeroCnt + CNTW'(1);
    end
  end

  // Per-block all-zero decision from bitstream flags only
  for (genvar g = 0; g < NUM_BLOCKS; g++) begin : g_skip
    assign blkSkip[g] = codQ | (interQ & ~cbpQ[g] & ~dcQ[g]);
  end

  assign blkSkipPad = (2**IDXW)'(blkSkip);
  assign skipNow    = blkSkipPad[blkIdx];
  assign lastBlk    = (blkIdx == IDXW'(NUM_BLOCKS - 1));
  assign lastSample = (zeroCnt == CNTW'(SAMPLES - 1));
endmodule

// File: rtl/zblk_ctrl.sv
module zblk_ctrl
  import zblk_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    mbStart,
  input  logic    idctDone,
  input  logic    skipNow,
  input  logic    lastBlk,
  input  logic    lastSample,
  output strobe_t strobe,
  output logic    mbReady,
  output logic    idctClkEn,
  output logic    idctStart,
  output logic    bypass,
  output logic    mbDone
);
  state_t state;
  state_t stateNxt;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNxt;
  end

  always_comb begin
    stateNxt = state;
    unique case (state)
      ST_IDLE:   if (mbStart) stateNxt = ST_DECIDE;
      ST_DECIDE: stateNxt = skipNow ? ST_ZERO : ST_RUN;
      ST_RUN:    if (idctDone) stateNxt = ST_NEXT;
      ST_ZERO:   if (lastSample) stateNxt = ST_NEXT;
      ST_NEXT:   stateNxt = lastBlk ? ST_IDLE : ST_DECIDE;
      default:   stateNxt = ST_IDLE;
    endcase
  end

  always_comb begin
    strobe        = '0;
    strobe.load   = (state == ST_IDLE) && mbStart;
    strobe.incIdx = (state == ST_NEXT) && !lastBlk;
    strobe.clrCnt = (state == ST_DECIDE);
    strobe.incCnt = (state == ST_ZERO);
  end

  // Enable drops in the decide cycle of a skipped block, ahead of bypass
  assign idctClkEn = ((state == ST_DECIDE) && !skipNow) || (state == ST_RUN);
  assign idctStart = (state == ST_DECIDE) && !skipNow;
  assign bypass    = (state == ST_ZERO);
  assign mbReady   = (state == ST_IDLE);
  assign mbDone    = (state == ST_NEXT) && lastBlk;
endmodule

// File: rtl/zblk_skip_ctrl.sv
module zblk_skip_ctrl
  import zblk_pkg::*;
#(
  parameter int NUM_BLOCKS = 6,
  parameter int SAMPLES    = 64,
  localparam int IDXW = $clog2(NUM_BLOCKS)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  mbStart,
  input  logic                  codIn,
  input  logic [NUM_BLOCKS-1:0] cbpIn,
  input  logic [NUM_BLOCKS-1:0] dcNzIn,
  input  logic                  isInter,
  input  logic                  idctDone,
  output logic                  mbReady,
  output logic                  idctClkEn,
  output logic                  idctStart,
  output logic                  bypass,
  output logic [IDXW-1:0]       blkIdx,
  output logic                  mbDone
);
  strobe_t strobe;
  logic    skipNow;
  logic    lastBlk;
  logic    lastSample;

  zblk_ctrl ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .mbStart    (mbStart),
    .idctDone   (idctDone),
    .skipNow    (skipNow),
    .lastBlk    (lastBlk),
    .lastSample (lastSample),
    .strobe     (strobe),
    .mbReady    (mbReady),
    .idctClkEn  (idctClkEn),
    .idctStart  (idctStart),
    .bypass     (bypass),
    .mbDone     (mbDone)
  );

  zblk_dp #(
    .NUM_BLOCKS (NUM_BLOCKS),
    .SAMPLES    (SAMPLES)
  ) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .codIn      (codIn),
    .cbpIn      (cbpIn),
    .dcNzIn     (dcNzIn),
    .isInter    (isInter),
    .blkIdx     (blkIdx),
    .skipNow    (skipNow),
    .lastBlk    (lastBlk),
    .lastSample (lastSample)
  );
endmodule

// File: rtl/zblk_chk.sv
module zblk_chk #(
  parameter int NUM_BLOCKS = 6,
  localparam int IDXW = $clog2(NUM_BLOCKS)
) (
  input logic            clk,
  input logic            rstN,
  input logic            idctDone,
  input logic            mbReady,
  input logic            idctClkEn,
  input logic            idctStart,
  input logic            bypass,
  input logic [IDXW-1:0] blkIdx,
  input logic            mbDone
);
  a_r6_no_clk_in_bypass: assert property (@(posedge clk) disable iff (!rstN)
    !(idctClkEn && bypass));

  a_r7_gate_before_bypass: assert property (@(posedge clk) disable iff (!rstN)
    $rose(bypass) |-> !$past(idctClkEn));

  a_r7_start_with_clk: assert property (@(posedge clk) disable iff (!rstN)
    idctStart |-> idctClkEn && !bypass);

  a_r8_hold_until_done: assert property (@(posedge clk) disable iff (!rstN)
    (idctClkEn && !idctStart && !idctDone) |=> idctClkEn);

  a_r6_idx_steady: assert property (@(posedge clk) disable iff (!rstN)
    (bypass && $past(bypass)) |-> $stable(blkIdx));

  a_r9_done_then_ready: assert property (@(posedge clk) disable iff (!rstN)
    mbDone |=> mbReady);

  a_r9_done_on_last: assert property (@(posedge clk) disable iff (!rstN)
    mbDone |-> (blkIdx == IDXW'(NUM_BLOCKS - 1)));

  a_r2_idx_range: assert property (@(posedge clk) disable iff (!rstN)
    blkIdx < IDXW'(NUM_BLOCKS));
endmodule

bind zblk_skip_ctrl zblk_chk #(.NUM_BLOCKS(NUM_BLOCKS)) chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .idctDone  (idctDone),
  .mbReady   (mbReady),
  .idctClkEn (idctClkEn),
  .idctStart (idctStart),
  .bypass    (bypass),
  .blkIdx    (blkIdx),
  .mbDone    (mbDone)
);

// File: tb/zblk_skip_ctrl_tb_top.sv
module zblk_skip_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       mbStart = 1'b0;
  logic       codIn = 1'b0;
  logic [5:0] cbpIn = '0;
  logic [5:0] dcNzIn = '0;
  logic       isInter = 1'b0;
  logic       idctDone = 1'b0;
  logic       mbReady, idctClkEn, idctStart, bypass, mbDone;
  logic [2:0] blkIdx;

  int nChecks = 0;
  int nFails  = 0;
  int cycles  = 0;
  bit ended   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  zblk_skip_ctrl dut_i (
    .clk(clk), .rstN(rstN), .mbStart(mbStart), .codIn(codIn), .cbpIn(cbpIn),
    .dcNzIn(dcNzIn), .isInter(isInter), .idctDone(idctDone), .mbReady(mbReady),
    .idctClkEn(idctClkEn), .idctStart(idctStart), .bypass(bypass),
    .blkIdx(blkIdx), .mbDone(mbDone)
  );

  task automatic chk(string tag, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", tag, act, exp, $time);
    end
  endtask

  function automatic bit expSkip(bit cod, bit inter, bit [5:0] cbp, bit [5:0] dc, int b);
    return cod || (inter && !cbp[b] && !dc[b]);
  endfunction

  task automatic finishRun();
    if (!ended) begin
      ended = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  endtask

  // Run one macroblock; bench plays the transform with random latency
  task automatic runMb(bit cod, bit inter, bit [5:0] cbp, bit [5:0] dc, bit junk);
    @(negedge clk);
    chk("R9 ready before start", int'(mbReady), 1);
    codIn = cod; isInter = inter; cbpIn = cbp; dcNzIn = dc; mbStart = 1'b1;
    @(negedge clk);
    mbStart = 1'b0;
    for (int b = 0; b < 6; b++) begin
      bit sk = expSkip(cod, inter, cbp, dc, b);
      if (junk) begin // R10: noise while busy
        mbStart = 1'($urandom); codIn = 1'($urandom); isInter = 1'($urandom);
        cbpIn = 6'($urandom); dcNzIn = 6'($urandom);
      end
      // decision cycle
      chk("R2 block index", int'(blkIdx), b);
      chk(cod ? "R4 clkEn at decide" : (inter ? "R3 clkEn at decide" : "R5 clkEn at decide"),
          int'(idctClkEn), int'(!sk));
      chk("R7 start strobe", int'(idctStart), int'(!sk));
      @(negedge clk);
      if (sk) begin
        int n = 0;
        while (bypass && n < 100) begin
          if (idctClkEn || blkIdx != 3'(b)) chk("R6 clkEn low, index steady", 1, 0);
          n++;
          @(negedge clk);
        end
        chk("R6 bypass length", n, 64);
      end else begin
        int lat = $urandom_range(0, 5);
        for (int k = 0; k < lat; k++) begin
          if (!idctClkEn || bypass || idctStart) chk("R8 hold while running", 0, 1);
          @(negedge clk);
        end
        chk("R8 clkEn before done", int'(idctClkEn), 1);
        chk("R10 no bypass on coded block", int'(bypass), 0);
        idctDone = 1'b1;
        @(negedge clk);
        idctDone = 1'b0;
      end
      // block-end cycle
      if (b == 5) mbStart = 1'b0;
      chk("R8 clkEn off after block", int'(idctClkEn), 0);
      chk("R9 done pulse", int'(mbDone), int'(b == 5));
      @(negedge clk);
    end
    mbStart = 1'b0;
    chk("R9 idle after macroblock", int'(mbReady), 1);
  endtask

  initial begin
    while (!ended) begin
      @(posedge clk);
      cycles++;
      if (cycles > WATCHDOG) begin
        nChecks++; nFails++;
        $display("FAIL watchdog: actual %0d expected below %0d cycles", cycles, WATCHDOG);
        finishRun();
      end
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 mbReady", int'(mbReady), 1);
    chk("R1 idctClkEn", int'(idctClkEn), 0);
    chk("R1 idctStart", int'(idctStart), 0);
    chk("R1 bypass", int'(bypass), 0);
    chk("R1 mbDone", int'(mbDone), 0);
    // directed corners
    runMb(1'b1, 1'b1, 6'b111111, 6'b111111, 1'b0); // R4 override
    runMb(1'b0, 1'b0, 6'b000000, 6'b000000, 1'b0); // R5 intra
    runMb(1'b0, 1'b1, 6'b000000, 6'b000000, 1'b0); // R3 all skip
    runMb(1'b0, 1'b1, 6'b111111, 6'b000000, 1'b0); // R3 cbp alone
    runMb(1'b0, 1'b1, 6'b000000, 6'b111111, 1'b0); // R3 dc alone
    runMb(1'b0, 1'b1, 6'b010101, 6'b100000, 1'b0); // R2 bit positions
    runMb(1'b0, 1'b1, 6'b000001, 6'b000000, 1'b1); // R10 junk while busy
    // random mix
    for (int i = 0; i < 30; i++) begin
      runMb(($urandom_range(0, 7) == 0), 1'($urandom), 6'($urandom), 6'($urandom), 1'($urandom));
    end
    finishRun();
  end
endmodule